// File: doc/BRIEF.md
# NAND Block Erase Command Controller

This block is the command front end and erase sequencer of a NAND-style flash die. A host writes bytes over an 8-bit bus. Each byte is latched on the rising edge of the active-low write strobe. A command-latch qualifier marks the byte as a command code, and an address-latch qualifier marks it as an address byte. The controller recognises the block erase sequence: setup code, a fixed number of address bytes, confirm code. It then holds the ready line low while it fills the addressed block of a small internal byte array with ones, one byte per clock.

Alongside erase, the controller answers a status-read command, which switches the output bus to a status byte, and a reset command. The reset command aborts an erase in progress and leaves the block partly erased. A reset that arrives while the device already sits in its reset state is refused. A test input forces the erase result to fail, and a side read port exposes the array so the erase effect can be observed.

Top module: `nand_erase_ctrl`

## Requirements
- R1: After the reset input, ready is 1, io_out is 00h, and every array byte is 00h.
- R2: A byte is taken as a command on a rising edge of wr_n with cmd_latch=1 and addr_latch=0. The sequence 60h, then ADDR_CYC address bytes, then D0h starts an erase at the edge that latches D0h, and ready stays 0 for ERASE_CYC clock cycles.
- R3: Address bytes are taken on a rising edge of wr_n with addr_latch=1 and cmd_latch=0, first byte as bits 7:0 and later bytes as higher bits. The block index is bits BLK_LSB+BLK_BITS-1 down to BLK_LSB, and all other address bits are ignored.
- R4: A completed erase leaves every byte of the addressed block at FFh and leaves other blocks unchanged.
- R5: D0h without a preceding 60h and a full set of address bytes is ignored: ready stays 1 and the array is unchanged.
- R6: While ready is 0, only 70h and FFh are accepted. Any other code, such as 60h, has no effect on the busy time or the state.
- R7: The status byte has bit 6 equal to ready, bit 0 equal to the fail flag, and all other bits 0. After 70h, io_out shows it until another accepted command. Otherwise io_out is 00h.
- R8: fail_force is sampled at the end of an erase and sets status bit 0. Bit 0 is cleared when an erase starts and when a reset command is accepted.
- R9: FFh during an erase aborts it. Bytes already erased stay FFh, the rest keep their old contents, and ready is 0 for RST_ERASE_CYC cycles from the latching edge.
- R10: FFh outside an erase, when the device is not in its reset state, makes ready 0 for RST_IDLE_CYC cycles.
- R11: The device is in its reset state after the reset input and after a reset command completes, until the next 60h. FFh in that state, or during a reset busy period, is refused and ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_latch | input | 1 | Marks the bus byte as a command |
| addr_latch | input | 1 | Marks the bus byte as an address byte |
| wr_n | input | 1 | Active-low write strobe, latched on its rising edge |
| io_in | input | 8 | Bus byte from the host |
| io_out | output | 8 | Status byte in status mode, else 00h |
| ready | output | 1 | 1 when idle, 0 during erase or reset busy |
| fail_force | input | 1 | Forces the erase result to fail |
| peek_addr | input | BLK_BITS+WORD_BITS | Array byte index {block, word} |
| peek_data | output | 8 | Array byte at peek_addr |

## Verification
A bus byte takes effect at the clock edge that first samples wr_n high after a low cycle. State, ready and io_out therefore change at that edge and are sampled on the following falling edge. An erase or reset busy period entered at edge E ends at edge E+N, so the bench counts falling edges with ready low, starting right after the latching edge, and expects exactly N. When commands are issued during a busy period, each two-cycle write is subtracted from that count. The abort test relies on the byte at word k being written at edge E+1+k, which puts exactly two bytes at FFh when FFh is latched two edges after D0h.

// File: rtl/nand_erase_ctrl.sv
module nand_erase_ctrl #(
  parameter int ADDR_CYC      = 3,
  parameter int BLK_BITS      = 3,
  parameter int WORD_BITS     = 3,
  parameter int BLK_LSB       = 6,
  parameter int ERASE_CYC     = 24,
  parameter int RST_IDLE_CYC  = 4,
  parameter int RST_ERASE_CYC = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_latch,
  input  logic                          addr_latch,
  input  logic                          wr_n,
  input  logic [7:0]                    io_in,
  output logic [7:0]                    io_out,
  output logic                          ready,
  input  logic                          fail_force,
  input  logic [BLK_BITS+WORD_BITS-1:0] peek_addr,
  output logic [7:0]                    peek_data
);
  localparam int NWORD = 1 << WORD_BITS;
  localparam int NBYTE = 1 << (BLK_BITS + WORD_BITS);
  localparam int CNT_W = $clog2(ERASE_CYC + RST_IDLE_CYC + RST_ERASE_CYC + 1);
  localparam int ACW   = $clog2(ADDR_CYC + 1);

  localparam logic [2:0] S_IDLE  = 3'd0;
  localparam logic [2:0] S_ADDR  = 3'd1;
  localparam logic [2:0] S_CONF  = 3'd2;
  localparam logic [2:0] S_ERASE = 3'd3;
  localparam logic [2:0] S_RBUSY = 3'd4;

  logic [2:0]          st;
  logic                wr_q;
  logic [CNT_W-1:0]    cnt;
  logic [ACW-1:0]      acnt;
  logic [BLK_BITS-1:0] blk_acc, blk_q;
  logic                stat_mode, fail_q, rst_state;
  logic [7:0]          mem [NBYTE];

  wire wr_edge = wr_n & ~wr_q;
  wire cmd_wr  = wr_edge & cmd_latch & ~addr_latch;
  wire adr_wr  = wr_edge & addr_latch & ~cmd_latch;
  wire is_setup = io_in == 8'h60;
  wire is_conf  = io_in == 8'hD0;
  wire is_stat  = io_in == 8'h70;
  wire is_rst   = io_in == 8'hFF;

  assign ready     = (st != S_ERASE) && (st != S_RBUSY);
  assign io_out    = stat_mode ? {1'b0, ready, 5'b0, fail_q} : 8'h00;
  assign peek_data = mem[peek_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      wr_q      <= 1'b1;
      cnt       <= '0;
      acnt      <= '0;
      blk_acc   <= '0;
      blk_q     <= '0;
      stat_mode <= 1'b0;
      fail_q    <= 1'b0;
      rst_state <= 1'b1;
      for (int i = 0; i < NBYTE; i++) mem[i] <= 8'h00;
    end else begin
      wr_q <= wr_n;
      case (st)
        S_ERASE: begin
          if (int'(cnt) < NWORD) mem[{blk_q, cnt[WORD_BITS-1:0]}] <= 8'hFF;
          if (cnt == CNT_W'(ERASE_CYC - 1)) begin
            st     <= S_IDLE;
            fail_q <= fail_force;
          end else begin
            cnt <= cnt + 1'b1;
          end
          if (cmd_wr && is_stat) stat_mode <= 1'b1;
          if (cmd_wr && is_rst) begin
            st        <= S_RBUSY;
            cnt       <= CNT_W'(RST_ERASE_CYC - 1);
            stat_mode <= 1'b0;
            fail_q    <= 1'b0;
          end
        end
        S_RBUSY: begin
          if (cnt == '0) begin
            st        <= S_IDLE;
            rst_state <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
          if (cmd_wr && is_stat) stat_mode <= 1'b1;
        end
        default: begin
          if (adr_wr && st == S_ADDR) begin
            for (int b = 0; b < BLK_BITS; b++)
              if ((BLK_LSB + b) / 8 == int'(acnt))
                blk_acc[b] <= io_in[(BLK_LSB + b) % 8];
            if (acnt == ACW'(ADDR_CYC - 1)) st <= S_CONF;
            else acnt <= acnt + 1'b1;
          end
          if (cmd_wr) begin
            if (is_conf && st == S_CONF) begin
              st        <= S_ERASE;
              cnt       <= '0;
              blk_q     <= blk_acc;
              stat_mode <= 1'b0;
              fail_q    <= 1'b0;
            end else if (is_setup) begin
              st        <= S_ADDR;
              acnt      <= '0;
              blk_acc   <= '0;
              stat_mode <= 1'b0;
              rst_state <= 1'b0;
            end else if (is_stat) begin
              st        <= S_IDLE;
              stat_mode <= 1'b1;
            end else if (is_rst && !rst_state) begin
              st        <= S_RBUSY;
              cnt       <= CNT_W'(RST_IDLE_CYC - 1);
              stat_mode <= 1'b0;
              fail_q    <= 1'b0;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_erase_chk.sv
module nand_erase_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [7:0] io_in,
  input logic [7:0] io_out,
  input logic       ready,
  input logic [2:0] st,
  input logic       rst_state,
  input logic       stat_mode
);
  // R7
  stat_ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_mode |-> io_out[6] == ready);

  // R2
  erase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && cmd_wr && io_in == 8'hD0) |=> (st == 3'd3 && !ready));

  // R5
  orphan_conf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && cmd_wr && io_in == 8'hD0) |=> (ready && st == 3'd0));

  // R6
  busy_setup_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && cmd_wr && io_in == 8'h60) |=> st != 3'd1);

  // R9
  erase_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd3 && cmd_wr && io_in == 8'hFF) |=> (st == 3'd4 && !ready));

  // R11
  repeat_reset_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_state && ready && cmd_wr && io_in == 8'hFF) |=> ready);
endmodule

bind nand_erase_ctrl nand_erase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .io_in(io_in), .io_out(io_out),
  .ready(ready), .st(st), .rst_state(rst_state), .stat_mode(stat_mode)
);

// File: tb/tb_nand_erase_ctrl.sv
module tb_nand_erase_ctrl;
  localparam int ERASE_CYC = 24, RST_IDLE_CYC = 4, RST_ERASE_CYC = 12;

  logic clk = 0, rst_n = 0, cmd_latch = 0, addr_latch = 0, wr_n = 1, fail_force = 0;
  logic [7:0] io_in = 0, io_out, peek_data;
  logic [5:0] peek_addr = 0;
  logic ready;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  nand_erase_ctrl #(.ADDR_CYC(3), .BLK_BITS(3), .WORD_BITS(3), .BLK_LSB(6),
    .ERASE_CYC(ERASE_CYC), .RST_IDLE_CYC(RST_IDLE_CYC), .RST_ERASE_CYC(RST_ERASE_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_latch(cmd_latch), .addr_latch(addr_latch), .wr_n(wr_n),
    .io_in(io_in), .io_out(io_out), .ready(ready), .fail_force(fail_force),
    .peek_addr(peek_addr), .peek_data(peek_data));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk); cmd_latch = c; addr_latch = a; io_in = d; wr_n = 0;
    @(negedge clk); wr_n = 1;
  endtask

  task automatic send_addr(input logic [2:0] blk);
    wr(0, 1, {blk[1:0], 6'h15});
    wr(0, 1, {7'h7C, blk[2]});
    wr(0, 1, 8'hAB);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (ready) break;
      n++;
    end
  endtask

  task automatic peek(input logic [2:0] blk, input logic [2:0] w, output logic [7:0] v);
    peek_addr = {blk, w}; #1; v = peek_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    int n;
    @(negedge clk);
    chk("R1 ready", int'(ready), 1);
    chk("R1 io_out", int'(io_out), 8'h00);
    peek(3'd2, 3'd0, v); chk("R1 array", int'(v), 8'h00);
    wr(1, 0, 8'hFF);
    busy_len(n); chk("R11 reset after power-up refused", n, 0);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    int n;
    wr(1, 0, 8'h60); send_addr(3'd2); wr(1, 0, 8'hD0);
    busy_len(n); chk("R2 erase busy length", n, ERASE_CYC);
    for (int w = 0; w < 8; w++) begin
      peek(3'd2, 3'(w), v); chk("R4 R3 block 2 erased", int'(v), 8'hFF);
    end
    peek(3'd1, 3'd0, v); chk("R4 block 1 untouched", int'(v), 8'h00);
    peek(3'd3, 3'd7, v); chk("R4 block 3 untouched", int'(v), 8'h00);
    chk("R7 io_out before status read", int'(io_out), 8'h00);
    wr(1, 0, 8'h70); @(negedge clk);
    chk("R7 status pass", int'(io_out), 8'h40);
  endtask

  task automatic t_orphan;
    logic [7:0] v;
    wr(1, 0, 8'hD0); @(negedge clk);
    chk("R5 lone confirm ready", int'(ready), 1);
    wr(1, 0, 8'h60); wr(0, 1, 8'h00); wr(1, 0, 8'hD0); @(negedge clk);
    chk("R5 short address confirm ready", int'(ready), 1);
    wr(1, 0, 8'h70);
    repeat (ERASE_CYC) @(negedge clk);
    peek(3'd0, 3'd0, v); chk("R5 block 0 unchanged", int'(v), 8'h00);
    chk("R7 status after lone confirm", int'(io_out), 8'h40);
  endtask

  task automatic t_busy_fail;
    logic [7:0] v;
    int n;
    fail_force = 1;
    wr(1, 0, 8'h60); send_addr(3'd5); wr(1, 0, 8'hD0);
    wr(1, 0, 8'h60);
    wr(1, 0, 8'h70); @(negedge clk);
    chk("R7 status while busy", int'(io_out), 8'h00);
    busy_len(n); chk("R6 busy time unchanged by 60h", n, ERASE_CYC - 5);
    chk("R8 status fail", int'(io_out), 8'h41);
    fail_force = 0;
    for (int w = 0; w < 8; w++) begin
      peek(3'd5, 3'(w), v); chk("R4 block 5 erased", int'(v), 8'hFF);
    end
  endtask

  task automatic t_reset_cmd;
    int n;
    wr(1, 0, 8'hFF);
    busy_len(n); chk("R10 reset busy length", n, RST_IDLE_CYC);
    chk("R7 reset leaves status mode", int'(io_out), 8'h00);
    wr(1, 0, 8'h70); @(negedge clk);
    chk("R8 reset clears fail", int'(io_out), 8'h40);
    wr(1, 0, 8'hFF);
    busy_len(n); chk("R11 repeated reset refused", n, 0);
  endtask

  task automatic t_abort;
    logic [7:0] v;
    int n;
    wr(1, 0, 8'h60); send_addr(3'd7); wr(1, 0, 8'hD0);
    wr(1, 0, 8'hFF);
    busy_len(n); chk("R9 abort busy length", n, RST_ERASE_CYC);
    peek(3'd7, 3'd0, v); chk("R9 word 0 erased", int'(v), 8'hFF);
    peek(3'd7, 3'd1, v); chk("R9 word 1 erased", int'(v), 8'hFF);
    peek(3'd7, 3'd2, v); chk("R9 word 2 kept", int'(v), 8'h00);
    peek(3'd7, 3'd7, v); chk("R9 word 7 kept", int'(v), 8'h00);
    wr(1, 0, 8'hFF);
    busy_len(n); chk("R11 reset after abort refused", n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_basic();
    t_orphan();
    t_busy_fail();
    t_reset_cmd();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule